// File: doc/BRIEF.md
# Edge-Selectable Wakeup Interrupt Controller

This block watches an input port of `W` pins (eight by default) and records a chosen transition on each pin in a sticky per-pin pending flag. Software reaches three per-pin registers (enable, edge polarity and pending) and a one-bit port-level interrupt enable through a small register bus. Each bus write can load a value, set the bits given by a mask or clear the bits given by a mask. The selected register can be read back combinationally.

The pending flags that are also enabled drive three outputs. The first is a wakeup request for a core that has stopped its clock. The second is a halt-permit signal that drops while any enabled flag is pending. The third is one shared interrupt request, gated by the port-level enable and by an external global interrupt enable. Each pin passes through a two-flop synchronizer. An edge is detected by comparing the synchronized value with its value one cycle earlier. The wakeup, permit and interrupt outputs are combinational from register state, so the wakeup path does not need a running core clock.

Top module: `wake_edge_ctrl`

## Requirements
- R1: After reset, the enable, edge, pending and control registers all read 0, `wake_req` is 0, `irq_req` is 0 and `halt_permit` is 1.
- R2: A bus write (`reg_wr`=1) acts on the register chosen by `reg_sel` (0 enable, 1 edge, 2 pending, 3 control, where bit 0 is the port interrupt enable). The operation is set by `reg_op`: 0 loads `reg_wdata`, 1 ORs it in, 2 clears the bits that are 1 in it, and 3 leaves the register unchanged. `reg_rdata` shows the selected register.
- R3: When edge bit = 0, a low-to-high transition on the pin sets its pending bit. A high-to-low transition does not.
- R4: When edge bit = 1, a high-to-low transition sets the pending bit. A low-to-high transition does not.
- R5: A pending bit is set whatever its enable bit is. It stays set until software clears it.
- R6: `wake_req` is 1 exactly when some pin has both its enable bit and its pending bit set. It follows a register change in the same cycle.
- R7: `halt_permit` is 0 while some pin is both enabled and pending, and is 1 otherwise.
- R8: `irq_req` is 1 only when `gie`, the control enable bit and some enabled-and-pending pin are all 1.
- R9: If a software clear and a detected edge hit the same pending bit in the same cycle, the bit ends up set.
- R10: A pin change driven just after a clock edge becomes visible in the pending register after the third rising edge. It is not yet visible after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_in | input | W | Monitored pins, asynchronous |
| gie | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_op | input | 2 | Write operation: load, set, clear, none |
| reg_wdata | input | W | Write data or bit mask |
| reg_rdata | output | W | Readback of the selected register |
| wake_req | output | 1 | Wakeup request |
| irq_req | output | 1 | Shared port interrupt request |
| halt_permit | output | 1 | Halt entry is allowed |

## Verification
A bus write takes effect at the next rising edge. The three combinational outputs and the readback are therefore due in the same cycle the driver releases the write, and the bench samples them at the following falling edge. A pin change passes through two synchronizer flops and the pending register, so it is due after the third rising edge. The bench checks the pending value after the second edge (still clear) and after the third (set). For the clear-versus-edge collision, the driver times its clear write to land on exactly that third edge.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_EDGE   = 2'd1,
    SEL_PEND   = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } reg_op_e;
endpackage

// File: rtl/wake_pin_sync.sv
module wake_pin_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] sync_now,
  output logic [W-1:0] sync_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q    <= '0;
      sync_now  <= '0;
      sync_prev <= '0;
    end else begin
      meta_q    <= pins;
      sync_now  <= meta_q;
      sync_prev <= sync_now;
    end
  end
endmodule

// File: rtl/wake_pend_bank.sv
module wake_pend_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_now,
  input  logic [W-1:0] sync_prev,
  input  logic [W-1:0] edge_sel,
  input  logic         sw_we,
  input  logic [W-1:0] sw_val,
  output logic [W-1:0] hit,
  output logic [W-1:0] pend_q
);
  // edge_sel 1 means falling, 0 means rising
  function automatic logic hit_of(input logic now_v, input logic prev_v,
                                  input logic fall);
    return fall ? (prev_v & ~now_v) : (now_v & ~prev_v);
  endfunction

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign hit[i] = hit_of(sync_now[i], sync_prev[i], edge_sel[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend_q[i] <= 1'b0;
      else if (hit[i]) pend_q[i] <= 1'b1;
      else if (sw_we)  pend_q[i] <= sw_val[i];
    end

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> pend_q[i]); // R9
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q[i] && !sw_we |=> pend_q[i]); // R5
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_q[i] && !hit[i] && !sw_we |=> !pend_q[i]); // R3
  end
endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  reg_sel_e     sel,
  input  reg_op_e      op,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pend_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] edge_q,
  output logic         port_en_q,
  output logic         pend_we,
  output logic [W-1:0] pend_val,
  output logic [W-1:0] rdata
);
  function automatic logic [W-1:0] apply_op(input logic [W-1:0] cur,
                                            input reg_op_e o,
                                            input logic [W-1:0] d);
    case (o)
      OP_LOAD:  return d;
      OP_SET:   return cur | d;
      OP_CLEAR: return cur & ~d;
      default:  return cur;
    endcase
  endfunction

  logic [W-1:0] ctrl_vec;
  logic [W-1:0] ctrl_next;

  assign ctrl_vec  = {{(W-1){1'b0}}, port_en_q};
  assign ctrl_next = apply_op(ctrl_vec, op, wdata);
  assign pend_we   = wr && (sel == SEL_PEND);
  assign pend_val  = apply_op(pend_q, op, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      edge_q    <= '0;
      port_en_q <= 1'b0;
    end else if (wr) begin
      case (sel)
        SEL_ENABLE: en_q      <= apply_op(en_q, op, wdata);
        SEL_EDGE:   edge_q    <= apply_op(edge_q, op, wdata);
        SEL_CTRL:   port_en_q <= ctrl_next[0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_ENABLE: rdata = en_q;
      SEL_EDGE:   rdata = edge_q;
      SEL_PEND:   rdata = pend_q;
      default:    rdata = ctrl_vec;
    endcase
  end

  AST_NONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr && op == OP_NONE |=> $stable(en_q) && $stable(edge_q) && $stable(port_en_q)); // R2
endmodule

// File: rtl/wake_edge_ctrl.sv
module wake_edge_ctrl
  import wake_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] port_in,
  input  logic         gie,
  input  logic         reg_wr,
  input  logic [1:0]   reg_sel,
  input  logic [1:0]   reg_op,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         wake_req,
  output logic         irq_req,
  output logic         halt_permit
);
  logic [W-1:0] sync_now, sync_prev, hit, pend_q;
  logic [W-1:0] en_q, edge_q, pend_val;
  logic         port_en_q, pend_we;
  logic [W-1:0] armed;

  wake_pin_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins(port_in),
    .sync_now(sync_now), .sync_prev(sync_prev)
  );

  wake_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr),
    .sel(reg_sel_e'(reg_sel)), .op(reg_op_e'(reg_op)), .wdata(reg_wdata),
    .pend_q(pend_q), .en_q(en_q), .edge_q(edge_q), .port_en_q(port_en_q),
    .pend_we(pend_we), .pend_val(pend_val), .rdata(reg_rdata)
  );

  wake_pend_bank #(.W(W)) u_pend (
    .clk(clk), .rst_n(rst_n), .sync_now(sync_now), .sync_prev(sync_prev),
    .edge_sel(edge_q), .sw_we(pend_we), .sw_val(pend_val),
    .hit(hit), .pend_q(pend_q)
  );

  // Combinational so a stopped core clock does not block wakeup
  assign armed       = en_q & pend_q;
  assign wake_req    = |armed;
  assign halt_permit = ~|armed;
  assign irq_req     = gie & port_en_q & wake_req;

  AST_WAKE_VS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req != halt_permit); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake_req && gie && port_en_q); // R8
  AST_WAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (pend_q != '0) && (en_q != '0)); // R6
endmodule

// File: tb/wake_edge_ctrl_tb.sv
module wake_edge_ctrl_tb_top;
  localparam int W = 8;
  localparam int K_RD = 0, K_WAKE = 1, K_IRQ = 2, K_PERMIT = 3;

  logic         clk = 0, rst_n = 0, gie = 0, reg_wr = 0;
  logic [W-1:0] port_in = '0, reg_wdata = '0;
  logic [1:0]   reg_sel = 0, reg_op = 0;
  logic [W-1:0] reg_rdata;
  logic         wake_req, irq_req, halt_permit;

  wake_edge_ctrl #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .port_in(port_in), .gie(gie),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_op(reg_op), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wake_req(wake_req), .irq_req(irq_req),
    .halt_permit(halt_permit)
  );

  always #10 clk = ~clk;

  typedef struct {
    string      req;
    int         kind;
    logic [7:0] exp;
  } exp_t;

  exp_t q[$];
  int   compared = 0, mismatched = 0;
  bit   finished = 0;

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic push(input string req, input int kind, input logic [7:0] v);
    exp_t e;
    e.req = req; e.kind = kind; e.exp = v;
    q.push_back(e);
  endtask

  task automatic rd(input logic [1:0] sel, input logic [7:0] v, input string req);
    reg_sel = sel;
    push(req, K_RD, v);
    step();
  endtask

  task automatic outs(input logic w, input logic i, input logic p, input string req);
    push(req, K_WAKE, {7'd0, w});
    push(req, K_IRQ, {7'd0, i});
    push(req, K_PERMIT, {7'd0, p});
    step();
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] op, input logic [7:0] d);
    reg_sel = sel; reg_op = op; reg_wdata = d; reg_wr = 1;
    step();
    reg_wr = 0;
  endtask

  // Monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        logic [7:0] act;
        e = q.pop_front();
        case (e.kind)
          K_RD:    act = reg_rdata;
          K_WAKE:  act = {7'd0, wake_req};
          K_IRQ:   act = {7'd0, irq_req};
          default: act = {7'd0, halt_permit};
        endcase
        compared++;
        if (act !== e.exp) begin
          mismatched++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", e.req, e.kind, act, e.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    step();
    // R1 reset state
    rd(0, 8'h00, "R1"); rd(1, 8'h00, "R1"); rd(2, 8'h00, "R1"); rd(3, 8'h00, "R1");
    outs(0, 0, 1, "R1");

    // R2 bus operations
    wr(0, 0, 8'hA5); rd(0, 8'hA5, "R2");
    wr(0, 1, 8'h0A); rd(0, 8'hAF, "R2");
    wr(0, 2, 8'h05); rd(0, 8'hAA, "R2");
    wr(0, 3, 8'h00); rd(0, 8'hAA, "R2");
    wr(1, 0, 8'h3C); rd(1, 8'h3C, "R2");
    wr(2, 0, 8'h81); rd(2, 8'h81, "R2");
    wr(3, 1, 8'hFF); rd(3, 8'h01, "R2");
    wr(0, 0, 8'h00); wr(1, 0, 8'h00); wr(2, 0, 8'h00); wr(3, 0, 8'h00);

    // R3 / R10 rising edge with edge bit 0
    port_in[0] = 1;
    reg_sel = 2;
    step(); step();
    rd(2, 8'h00, "R10");
    rd(2, 8'h01, "R3");
    port_in[0] = 0;
    step(); step(); step();
    rd(2, 8'h01, "R3");

    // R4 falling edge with edge bit 1 on pin 1
    wr(2, 0, 8'h00);
    wr(1, 1, 8'h02);
    port_in[1] = 1;
    step(); step(); step(); step();
    rd(2, 8'h00, "R4");
    port_in[1] = 0;
    step(); step(); step();
    rd(2, 8'h02, "R4");
    // R5 set without enable, no wakeup
    outs(0, 0, 1, "R5");

    // R6 / R7 enable it
    wr(0, 0, 8'h02);
    outs(1, 0, 0, "R6");
    // R8 gating
    wr(3, 0, 8'h01);
    outs(1, 0, 0, "R8");
    gie = 1;
    outs(1, 1, 0, "R8");
    wr(3, 0, 8'h00);
    outs(1, 0, 0, "R8");
    gie = 0;
    // R5 sticky across many cycles
    repeat (10) step();
    rd(2, 8'h02, "R5");
    wr(2, 2, 8'h02);
    rd(2, 8'h00, "R5");
    outs(0, 0, 1, "R7");

    // R9 clear collides with edge on pin 2
    wr(1, 0, 8'h00);
    wr(2, 1, 8'h04);
    rd(2, 8'h04, "R9");
    port_in[2] = 1;
    step(); step();
    wr(2, 2, 8'h04);
    rd(2, 8'h04, "R9");
    wr(2, 2, 8'h04);
    rd(2, 8'h00, "R9");

    step(); step();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule